// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block owns the stack pointer of a small 8-bit processor and moves context bytes between the register file and a byte-wide memory port. The stack descends through memory: the pointer always names the next free byte. A push writes at the pointer and then moves the pointer down. A pull moves the pointer up and then reads at the new address.

A command strobe selects one of several sequences: load the pointer, subroutine call, subroutine return, interrupt entry, return from interrupt, or a single push or pull of A, B, X or Y. The snapshot of program counter and register values is taken when the command is accepted. One byte moves per clock while `busy` is high, and a one-cycle `done` pulse follows the last transfer. Pulled bytes land in the restored-register outputs.

Instruction decode, vector fetch and interrupt arbitration are outside this block. Only the stack traffic and the pointer update are handled here.

Top module: `stack_seq`

## Requirements
- R1: A load command (`cmd_op` = 1) accepted while idle sets `sp_out` to `sp_load_val` on the next clock, with no memory traffic and no `busy`.
- R2: Each pushed byte is written (`mem_we`) at the address equal to the current stack pointer, and the pointer then drops by one.
- R3: Each pulled byte is read (`mem_re`) at the stack pointer plus one, and the pointer then rises by one. Read data is taken from `mem_rdata` in the same cycle as the strobe.
- R4: A call (`cmd_op` = 2) pushes `pc_in` low byte first, then high byte, which leaves the pointer two lower.
- R5: A return (`cmd_op` = 3) pulls the high byte and then the low byte and reassembles them on `pc_out`.
- R6: Interrupt entry (`cmd_op` = 4) writes nine bytes at descending addresses in the order PC low, PC high, Y low, Y high, X low, X high, A, B, CCR.
- R7: Return from interrupt (`cmd_op` = 5) pulls nine bytes in the exact reverse of R6, CCR first and PC low last, restoring all of `ccr_out`, `b_out`, `a_out`, `x_out`, `y_out` and `pc_out`.
- R8: Single-register commands push A, B, X, Y (`cmd_op` = 6, 7, 8, 9) and pull A, B, X, Y (`cmd_op` = 10, 11, 12, 13). A 16-bit register is pushed low byte then high byte and is pulled high byte then low byte.
- R9: A sequence of N bytes holds `busy` high for exactly N cycles with one transfer in each. `done` is high for the single cycle after the last transfer. `mem_we` and `mem_re` are never high together.
- R10: A command presented while `busy` is high is ignored. It starts no transfer and does not change the pointer.
- R11: The pointer wraps modulo 2^16 in both directions without any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code (see requirements) |
| sp_load_val | input | 16 | New pointer value for the load command |
| pc_in | input | 16 | Return address or current program counter |
| a_in | input | 8 | Accumulator A value to save |
| b_in | input | 8 | Accumulator B value to save |
| x_in | input | 16 | Index X value to save |
| y_in | input | 16 | Index Y value to save |
| ccr_in | input | 8 | Condition code value to save |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read strobe |
| sp_out | output | 16 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| a_out | output | 8 | Restored accumulator A |
| b_out | output | 8 | Restored accumulator B |
| x_out | output | 16 | Restored index X |
| y_out | output | 16 | Restored index Y |
| ccr_out | output | 8 | Restored condition codes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory returns read data combinationally in the same cycle as `mem_re`. They also assume that the reset is released synchronously to the clock, so that the first step after reset starts from a defined pointer. The bench models the memory as a combinational 256-byte window indexed by the low address byte. Every stack region it uses stays clear of aliasing, and the wrap test works across the 0x0000/0xFFFF boundary, whose low bytes remain distinct. Commands are applied at the falling edge and held for one cycle. The one deliberate command during a busy sequence is there to exercise the ignore rule.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_LDSP = 4'd1,  OP_CALL = 4'd2,  OP_RET  = 4'd3,
    OP_IRQ  = 4'd4,  OP_RTI  = 4'd5,  OP_PSHA = 4'd6,  OP_PSHB = 4'd7,
    OP_PSHX = 4'd8,  OP_PSHY = 4'd9,  OP_PULA = 4'd10, OP_PULB = 4'd11,
    OP_PULX = 4'd12, OP_PULY = 4'd13
  } op_e;

  typedef enum logic [3:0] {
    F_PCL, F_PCH, F_YL, F_YH, F_XL, F_XH, F_A, F_B, F_CCR
  } fld_e;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] x;
    logic [15:0] y;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  ccr;
  } ctx_t;

  localparam int FRAME_BYTES = 9;
  localparam int IDX_W       = $clog2(FRAME_BYTES + 1);

  function automatic logic [IDX_W-1:0] seq_len(op_e op);
    case (op)
      OP_IRQ, OP_RTI:                                     return IDX_W'(FRAME_BYTES);
      OP_CALL, OP_RET, OP_PSHX, OP_PSHY, OP_PULX, OP_PULY: return IDX_W'(2);
      OP_PSHA, OP_PSHB, OP_PULA, OP_PULB:                 return IDX_W'(1);
      default:                                            return '0;
    endcase
  endfunction

  function automatic logic is_pull(op_e op);
    return (op == OP_RET) || (op == OP_RTI) || (op == OP_PULA) ||
           (op == OP_PULB) || (op == OP_PULX) || (op == OP_PULY);
  endfunction

  // Map a pull command onto the push command that built its frame.
  function automatic op_e push_twin(op_e op);
    case (op)
      OP_RET:  return OP_CALL;
      OP_RTI:  return OP_IRQ;
      OP_PULA: return OP_PSHA;
      OP_PULB: return OP_PSHB;
      OP_PULX: return OP_PSHX;
      OP_PULY: return OP_PSHY;
      default: return op;
    endcase
  endfunction

  // Field stored by the idx-th push of a push-type command.
  function automatic fld_e push_field(op_e op, logic [IDX_W-1:0] idx);
    case (op)
      OP_CALL: return (idx == 0) ? F_PCL : F_PCH;
      OP_PSHX: return (idx == 0) ? F_XL : F_XH;
      OP_PSHY: return (idx == 0) ? F_YL : F_YH;
      OP_PSHA: return F_A;
      OP_PSHB: return F_B;
      default: begin
        case (idx)
          IDX_W'(0): return F_PCL;
          IDX_W'(1): return F_PCH;
          IDX_W'(2): return F_YL;
          IDX_W'(3): return F_YH;
          IDX_W'(4): return F_XL;
          IDX_W'(5): return F_XH;
          IDX_W'(6): return F_A;
          IDX_W'(7): return F_B;
          default:   return F_CCR;
        endcase
      end
    endcase
  endfunction

  // Pulls walk the twin frame from its far end.
  function automatic fld_e pull_field(op_e op, logic [IDX_W-1:0] idx);
    op_e tw;
    tw = push_twin(op);
    return push_field(tw, seq_len(tw) - idx - IDX_W'(1));
  endfunction

  function automatic logic [7:0] byte_of(fld_e f, ctx_t c);
    case (f)
      F_PCL:   return c.pc[7:0];
      F_PCH:   return c.pc[15:8];
      F_YL:    return c.y[7:0];
      F_YH:    return c.y[15:8];
      F_XL:    return c.x[7:0];
      F_XH:    return c.x[15:8];
      F_A:     return c.a;
      F_B:     return c.b;
      default: return c.ccr;
    endcase
  endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_dn,
  input  logic          step_up,
  output logic [AW-1:0] sp
);

  function automatic logic [AW-1:0] sp_next_dn(logic [AW-1:0] v);
    return v - AW'(1);
  endfunction

  function automatic logic [AW-1:0] sp_next_up(logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= '0;
    else if (load)    sp <= load_val;
    else if (step_dn) sp <= sp_next_dn(sp);
    else if (step_up) sp <= sp_next_up(sp);
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sp == $past(load_val));
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !load) |=> sp == AW'($past(sp) - AW'(1)));
  assert_pull_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !load && !step_dn) |=> sp == AW'($past(sp) + AW'(1)));
  assert_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_dn && !step_up) |=> $stable(sp));

endmodule

// File: rtl/stk_restore.sv
module stk_restore
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  fld_e       fld,
  input  logic [7:0] din,
  output ctx_t       ctx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctx <= '0;
    else if (wr_en) begin
      case (fld)
        F_PCL:   ctx.pc[7:0]  <= din;
        F_PCH:   ctx.pc[15:8] <= din;
        F_YL:    ctx.y[7:0]   <= din;
        F_YH:    ctx.y[15:8]  <= din;
        F_XL:    ctx.x[7:0]   <= din;
        F_XH:    ctx.x[15:8]  <= din;
        F_A:     ctx.a        <= din;
        F_B:     ctx.b        <= din;
        default: ctx.ccr      <= din;
      endcase
    end
  end

  assert_pcl_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fld == F_PCL) |=> ctx.pc[7:0] == $past(din));
  assert_ccr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fld == F_CCR) |=> ctx.ccr == $past(din));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctx));

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] sp_load_val,
  input  logic [15:0]   pc_in,
  input  logic [7:0]    a_in,
  input  logic [7:0]    b_in,
  input  logic [15:0]   x_in,
  input  logic [15:0]   y_in,
  input  logic [7:0]    ccr_in,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] sp_out,
  output logic [15:0]   pc_out,
  output logic [7:0]    a_out,
  output logic [7:0]    b_out,
  output logic [15:0]   x_out,
  output logic [15:0]   y_out,
  output logic [7:0]    ccr_out,
  output logic          busy,
  output logic          done
);

  op_e              op_in;
  op_e              op_q;
  logic [IDX_W-1:0] idx_q, len_q;
  logic             busy_q, done_q;
  ctx_t             snap_q, rest;

  // Named internal events used by the assertions.
  logic accept, start_seq, load_sp, push_now, pull_now, last_xfer;
  fld_e fld_now;

  assign op_in     = op_e'(cmd_op);
  assign accept    = cmd_valid && !busy_q;
  assign start_seq = accept && (seq_len(op_in) != '0);
  assign load_sp   = accept && (op_in == OP_LDSP);
  assign pull_now  = busy_q && is_pull(op_q);
  assign push_now  = busy_q && !is_pull(op_q);
  assign last_xfer = busy_q && (idx_q == len_q - IDX_W'(1));
  assign fld_now   = pull_now ? pull_field(op_q, idx_q) : push_field(op_q, idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      idx_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      snap_q <= '0;
    end else begin
      done_q <= last_xfer;
      if (start_seq) begin
        op_q   <= op_in;
        idx_q  <= '0;
        len_q  <= seq_len(op_in);
        busy_q <= 1'b1;
        snap_q <= '{pc: pc_in, x: x_in, y: y_in, a: a_in, b: b_in, ccr: ccr_in};
      end else if (busy_q) begin
        if (last_xfer) busy_q <= 1'b0;
        else           idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  stk_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_sp),
    .load_val (sp_load_val),
    .step_dn  (push_now),
    .step_up  (pull_now),
    .sp       (sp_out)
  );

  stk_restore u_rest (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (pull_now),
    .fld   (fld_now),
    .din   (mem_rdata),
    .ctx   (rest)
  );

  assign mem_we    = push_now;
  assign mem_re    = pull_now;
  assign mem_addr  = pull_now ? AW'(sp_out + AW'(1)) : sp_out;
  assign mem_wdata = push_now ? byte_of(fld_now, snap_q) : 8'h00;
  assign busy      = busy_q;
  assign done      = done_q;
  assign pc_out    = rest.pc;
  assign a_out     = rest.a;
  assign b_out     = rest.b;
  assign x_out     = rest.x;
  assign y_out     = rest.y;
  assign ccr_out   = rest.ccr;

  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_xfer) |=> (busy && $stable(op_q)));
  assert_call_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_now && op_q == OP_CALL && idx_q == '0) |-> mem_wdata == snap_q.pc[7:0]);

endmodule

// File: tb/stack_seq_tb.sv
`timescale 1ns/100ps
module stack_seq_tb_top;

  localparam logic [3:0] C_LDSP = 4'd1, C_CALL = 4'd2, C_RET = 4'd3, C_IRQ = 4'd4,
                         C_RTI = 4'd5, C_PSHA = 4'd6, C_PSHB = 4'd7, C_PSHX = 4'd8,
                         C_PSHY = 4'd9, C_PULA = 4'd10, C_PULB = 4'd11,
                         C_PULX = 4'd12, C_PULY = 4'd13;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [15:0] sp_load_val = '0, pc_in = '0, x_in = '0, y_in = '0;
  logic [7:0]  a_in = '0, b_in = '0, ccr_in = '0, mem_rdata;
  logic [15:0] mem_addr, sp_out, pc_out, x_out, y_out;
  logic [7:0]  mem_wdata, a_out, b_out, ccr_out;
  logic        mem_we, mem_re, busy, done;

  logic [7:0] mem [256];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [23:0] exp_wr[$];   // {addr, data}
  logic [15:0] exp_rd[$];

  always #2.5 clk = ~clk;

  stack_seq dut_i (.*);

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops the expected write or read on each transfer.
  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (exp_wr.size() == 0) chk(0, "R2 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [23:0] e;
        e = exp_wr.pop_front();
        chk({mem_addr, mem_wdata} == e, "R2/R4/R6/R8 write", {mem_addr, mem_wdata}, e);
      end
    end
    if (mem_re) begin
      if (exp_rd.size() == 0) chk(0, "R3 unexpected read", mem_addr, 0);
      else begin
        logic [15:0] e;
        e = exp_rd.pop_front();
        chk(mem_addr == e, "R3/R5/R7 read address", mem_addr, e);
      end
    end
  end

  task automatic exp_push(inout logic [15:0] sp, input logic [7:0] d);
    exp_wr.push_back({sp, d});
    sp = sp - 16'd1;
  endtask

  task automatic exp_pull(inout logic [15:0] sp);
    sp = sp + 16'd1;
    exp_rd.push_back(sp);
  endtask

  // Driver: issue one command, optionally poke a load while busy, count busy cycles.
  task automatic run_cmd(input logic [3:0] op, input int nbytes, input bit poke, input string req);
    int cnt = 0;
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) begin
      cnt++;
      if (poke && cnt == 2) begin
        cmd_op = C_LDSP; sp_load_val = 16'h0000; cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(cnt == nbytes, {req, " R9 busy length"}, cnt, nbytes);
    chk(done == (nbytes != 0), {req, " R9 done pulse"}, done, nbytes != 0);
    @(negedge clk);
    chk(!done, {req, " R9 done single"}, done, 0);
  endtask

  initial begin
    logic [15:0] sp;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re, "reset idle", {busy, done, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: load
    sp_load_val = 16'h01F0;
    run_cmd(C_LDSP, 0, 0, "R1");
    chk(sp_out == 16'h01F0, "R1 load", sp_out, 16'h01F0);
    sp = 16'h01F0;

    // R4: call
    pc_in = 16'h1234;
    exp_push(sp, 8'h34); exp_push(sp, 8'h12);
    run_cmd(C_CALL, 2, 0, "R4");
    chk(sp_out == 16'h01EE, "R4 sp after call", sp_out, 16'h01EE);

    // R5: return
    pc_in = 16'h0000;
    exp_pull(sp); exp_pull(sp);
    run_cmd(C_RET, 2, 0, "R5");
    chk(pc_out == 16'h1234, "R5 pc restored", pc_out, 16'h1234);
    chk(sp_out == 16'h01F0, "R3 sp after return", sp_out, 16'h01F0);

    // R6 + R10: interrupt frame with a load poked while busy
    pc_in = 16'hABCD; y_in = 16'h1122; x_in = 16'h3344;
    a_in = 8'h55; b_in = 8'h66; ccr_in = 8'hC7;
    exp_push(sp, 8'hCD); exp_push(sp, 8'hAB); exp_push(sp, 8'h22); exp_push(sp, 8'h11);
    exp_push(sp, 8'h44); exp_push(sp, 8'h33); exp_push(sp, 8'h55); exp_push(sp, 8'h66);
    exp_push(sp, 8'hC7);
    run_cmd(C_IRQ, 9, 1, "R6");
    chk(sp_out == 16'h01E7, "R10 sp unaffected by busy load", sp_out, 16'h01E7);

    // R7: return from interrupt with different inputs present
    pc_in = 16'hFFFF; y_in = 16'hFFFF; x_in = 16'hFFFF; a_in = 8'hFF; b_in = 8'hFF; ccr_in = 8'hFF;
    for (int i = 0; i < 9; i++) exp_pull(sp);
    run_cmd(C_RTI, 9, 0, "R7");
    chk({pc_out, y_out, x_out} == 48'hABCD_1122_3344, "R7 16-bit restore",
        {pc_out, y_out}, {16'hABCD, 16'h1122});
    chk({a_out, b_out, ccr_out} == 24'h5566C7, "R7 8-bit restore", {a_out, b_out, ccr_out}, 24'h5566C7);
    chk(sp_out == 16'h01F0, "R7 sp after rti", sp_out, 16'h01F0);

    // R8: single pushes and pulls
    a_in = 8'h5A; x_in = 16'hBEEF; y_in = 16'hC0DE;
    exp_push(sp, 8'h5A);
    run_cmd(C_PSHA, 1, 0, "R8 psha");
    exp_push(sp, 8'hEF); exp_push(sp, 8'hBE);
    run_cmd(C_PSHX, 2, 0, "R8 pshx");
    exp_push(sp, 8'hDE); exp_push(sp, 8'hC0);
    run_cmd(C_PSHY, 2, 0, "R8 pshy");
    exp_pull(sp); exp_pull(sp);
    run_cmd(C_PULY, 2, 0, "R8 puly");
    chk(y_out == 16'hC0DE, "R8 y pulled", y_out, 16'hC0DE);
    exp_pull(sp); exp_pull(sp);
    run_cmd(C_PULX, 2, 0, "R8 pulx");
    chk(x_out == 16'hBEEF, "R8 x pulled", x_out, 16'hBEEF);
    exp_pull(sp);
    run_cmd(C_PULA, 1, 0, "R8 pula");
    chk(a_out == 8'h5A, "R8 a pulled", a_out, 8'h5A);
    chk(sp_out == 16'h01F0, "R8 sp balanced", sp_out, 16'h01F0);

    // R11: wrap both ways
    sp_load_val = 16'h0000;
    run_cmd(C_LDSP, 0, 0, "R11 load");
    sp = 16'h0000;
    b_in = 8'h77;
    exp_push(sp, 8'h77);
    run_cmd(C_PSHB, 1, 0, "R11 pshb");
    chk(sp_out == 16'hFFFF, "R11 underflow wrap", sp_out, 16'hFFFF);
    exp_pull(sp);
    run_cmd(C_PULB, 1, 0, "R11 pulb");
    chk(b_out == 8'h77, "R11 b across wrap", b_out, 8'h77);
    chk(sp_out == 16'h0000, "R11 overflow wrap", sp_out, 16'h0000);

    chk(exp_wr.size() == 0, "R2 writes outstanding", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, "R3 reads outstanding", exp_rd.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule